// File: doc/BRIEF.md
# Stereo DC-Blocking High-Pass Filter

This block removes the DC offset from a stream of decimated stereo audio samples. Each of the two channels runs its own first-order recursive high-pass section, `y[n] = x[n] - x[n-1] + a*y[n-1]`. The pole `a` sits just inside the unit circle, at about 0.9995. The feedback multiply is built as a subtract of an arithmetic right shift (`a = 1 - 2^-LEAK_SHIFT`), so the block needs no multiplier. The accumulator keeps `FRAC_W` fractional guard bits below the sample LSB. The output is the floor of the accumulator, saturated back to the sample width.

Samples arrive as signed two's-complement words that share one `in_valid` strobe. The filtered pair appears one clock later, together with `out_valid`, and is held until the next accepted sample. With `bypass` high, the raw input is forwarded at the same latency and the filter state keeps tracking the input. The `clear` input is driven from the ADC-disable and powerdown conditions. It wipes all filter state, so the first sample after release is treated as if it follows silence.

Top module: `dcblk_hpf`

## Requirements
- R1: After reset, `out_valid` is 0 and both outputs are 0.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid`=1 and `clear`=0, and 0 otherwise. The outputs keep their value while no sample is accepted.
- R3: With `bypass`=0, each output equals floor(y) of the recursion `y = x - x_prev + (1 - 2^-11)*y_prev`, computed in ideal arithmetic, to within 2 LSB (default `LEAK_SHIFT`=11).
- R4: The first sample accepted after reset or clear is output unchanged, because the previous input and output are taken as 0.
- R5: Hold a constant input of 100000 after a clear. Within 26000 samples the output falls to magnitude 1 LSB or less.
- R6: Outputs saturate to the signed sample range, +2^23-1 and -2^23 at the default 24-bit width, and never wrap.
- R7: With `bypass`=1, the output equals the input sample with the same one-cycle latency. The filter state keeps updating, so filtering resumes seamlessly when `bypass` returns to 0.
- R8: `clear`=1 zeroes the stored state and both outputs and forces `out_valid` low in the next cycle. It takes priority over `in_valid`.
- R9: The left and right channels are independent. A constant zero on one channel gives output 0 on that channel whatever the other channel carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous wipe of filter state (ADC disable or powerdown) |
| bypass | input | 1 | 1 forwards raw samples; 0 filters |
| in_valid | input | 1 | Input sample pair strobe |
| in_left | input | SAMPLE_W | Left input sample, signed |
| in_right | input | SAMPLE_W | Right input sample, signed |
| out_valid | output | 1 | Output sample pair strobe |
| out_left | output | SAMPLE_W | Left output sample, signed |
| out_right | output | SAMPLE_W | Right output sample, signed |

## Verification
A corrupted feedback accumulator does not show up in one sample. It shows as a slow drift away from the floating-point model. For that reason every filtered sample is compared, and a long DC hold reveals a wrong leak shift through a residual that never decays. A stale previous-input register shows up in the very first sample after a clear, which must equal the input exactly. A state update that is skipped during bypass shows up in the first sample after bypass is released.

// File: rtl/dcblk_pkg.sv
// Package: default widths and the channel count shared by the filter modules.
package dcblk_pkg;
    localparam int DEF_SAMPLE_W   = 24;  // sample width in bits
    localparam int DEF_FRAC_W     = 12;  // guard bits below the sample LSB
    localparam int DEF_LEAK_SHIFT = 11;  // pole = 1 - 2^-DEF_LEAK_SHIFT
    localparam int NUM_CH         = 2;   // left and right
endpackage

// File: rtl/dcblk_sat.sv
// dcblk_sat: clamps a wide signed value to the OUT_W signed range.
// Assumes IN_W > OUT_W. Purely combinational.
module dcblk_sat #(
    parameter int IN_W  = 26,
    parameter int OUT_W = 24
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    localparam int TOP_W = IN_W - OUT_W + 1;

    logic fits;

    // Value fits when every bit from the sign position upward agrees.
    always_comb begin
        fits = (din[IN_W-1:OUT_W-1] == {TOP_W{1'b0}}) ||
               (din[IN_W-1:OUT_W-1] == {TOP_W{1'b1}});
        if (fits)
            dout = din[OUT_W-1:0];
        else if (din[IN_W-1])
            dout = {1'b1, {(OUT_W-1){1'b0}}};
        else
            dout = {1'b0, {(OUT_W-1){1'b1}}};
    end
endmodule

// File: rtl/dcblk_chan.sv
// dcblk_chan: one channel of the first-order DC-blocking recursion
//   y = x - x_prev + y - (y >>> LEAK_SHIFT), held with FRAC_W guard bits.
// Assumes in_valid marks one sample per strobe; clear wins over in_valid.
// Output is registered: one clock of latency, also when bypassed.
module dcblk_chan #(
    parameter int SAMPLE_W   = 24,
    parameter int FRAC_W     = 12,
    parameter int LEAK_SHIFT = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       bypass,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] x_in,
    output logic signed [SAMPLE_W-1:0] y_out
);
    localparam int ACC_W = SAMPLE_W + FRAC_W + 2;
    localparam int INT_W = SAMPLE_W + 2;

    logic signed [SAMPLE_W-1:0] x_prev;
    logic signed [ACC_W-1:0]    y_q;
    logic signed [ACC_W-1:0]    y_next;
    logic signed [ACC_W-1:0]    x_scaled;
    logic signed [ACC_W-1:0]    xp_scaled;
    logic signed [INT_W-1:0]    y_int;
    logic signed [SAMPLE_W-1:0] y_sat;

    // Next accumulator value: difference term plus leaky feedback.
    always_comb begin
        x_scaled  = ACC_W'(x_in) <<< FRAC_W;
        xp_scaled = ACC_W'(x_prev) <<< FRAC_W;
        y_next    = y_q + (x_scaled - xp_scaled) - (y_q >>> LEAK_SHIFT);
        y_int     = y_next[ACC_W-1:FRAC_W];
    end

    dcblk_sat #(.IN_W(INT_W), .OUT_W(SAMPLE_W)) u_sat (
        .din  (y_int),
        .dout (y_sat)
    );

    // State and output registers; clear and reset wipe everything.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            x_prev <= '0;
            y_q    <= '0;
            y_out  <= '0;
        end else if (in_valid) begin
            x_prev <= x_in;
            y_q    <= y_next;
            y_out  <= bypass ? x_in : y_sat;
        end
    end

    // R8
    clear_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (y_q == '0 && x_prev == '0 && y_out == '0));

    // R7
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bypass && !clear) |=> (y_out == $past(x_in)));

    // R2
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !clear) |=> $stable(y_out));
endmodule

// File: rtl/dcblk_hpf.sv
// dcblk_hpf: stereo DC-blocking high-pass filter. One dcblk_chan per
// channel, one shared valid strobe, bypass and clear.
// Assumes clear is held while the ADC is disabled or powered down.
module dcblk_hpf #(
    parameter int SAMPLE_W   = dcblk_pkg::DEF_SAMPLE_W,
    parameter int FRAC_W     = dcblk_pkg::DEF_FRAC_W,
    parameter int LEAK_SHIFT = dcblk_pkg::DEF_LEAK_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                bypass,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right
);
    localparam int NCH = dcblk_pkg::NUM_CH;

    logic signed [SAMPLE_W-1:0] ch_in  [NCH];
    logic signed [SAMPLE_W-1:0] ch_out [NCH];

    // Route stereo ports onto the channel arrays.
    always_comb begin
        ch_in[0]  = in_left;
        ch_in[1]  = in_right;
        out_left  = ch_out[0];
        out_right = ch_out[1];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dcblk_chan #(
            .SAMPLE_W   (SAMPLE_W),
            .FRAC_W     (FRAC_W),
            .LEAK_SHIFT (LEAK_SHIFT)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (clear),
            .bypass   (bypass),
            .in_valid (in_valid),
            .x_in     (ch_in[c]),
            .y_out    (ch_out[c])
        );
    end

    // Output strobe: one clock behind an accepted input.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clear) |=> out_valid);

    // R8
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear || !in_valid) |=> !out_valid);
endmodule

// File: tb/dcblk_hpf_tb.sv
module dcblk_hpf_tb;
    localparam int SW   = 24;
    localparam int SMAX = (1 << (SW - 1)) - 1;
    localparam int SMIN = -(1 << (SW - 1));
    localparam real A   = 1.0 - 1.0 / 2048.0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          bypass = 1'b0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_left = '0;
    logic [SW-1:0] in_right = '0;
    logic          out_valid;
    logic [SW-1:0] out_left;
    logic [SW-1:0] out_right;

    int  checks = 0;
    int  failures = 0;
    bit  finished = 1'b0;
    real my_l = 0.0, mxp_l = 0.0, my_r = 0.0, mxp_r = 0.0;

    always #2.5 clk = ~clk;

    dcblk_hpf u_dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .bypass(bypass),
        .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_out(input real y);
        int v;
        v = $rtoi($floor(y));
        if (v > SMAX) v = SMAX;
        if (v < SMIN) v = SMIN;
        return v;
    endfunction

    function automatic int sl();
        return int'($signed(out_left));
    endfunction
    function automatic int sr();
        return int'($signed(out_right));
    endfunction

    task automatic model_clear();
        my_l = 0.0; mxp_l = 0.0; my_r = 0.0; mxp_r = 0.0;
    endtask

    // Drive one sample pair at a falling edge; return after the next falling edge.
    task automatic push(input int xl, input int xr);
        in_valid = 1'b1;
        in_left  = xl[SW-1:0];
        in_right = xr[SW-1:0];
        my_l = real'(xl) - mxp_l + A * my_l; mxp_l = real'(xl);
        my_r = real'(xr) - mxp_r + A * my_r; mxp_r = real'(xr);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic cmp_model(input string req);
        int el, er, dl, dr;
        el = model_out(my_l);
        er = model_out(my_r);
        dl = sl() - el;
        dr = sr() - er;
        chk(dl <= 2 && dl >= -2, {req, " left"}, sl(), el);
        chk(dr <= 2 && dr >= -2, {req, " right"}, sr(), er);
    endtask

    task automatic do_clear();
        clear = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clear = 1'b0;
        model_clear();
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(sl() == 0, "R1 left", sl(), 0);
        chk(sr() == 0, "R1 right", sr(), 0);
    endtask

    task automatic t_first();
        do_clear();
        push(1000, -500);
        chk(out_valid == 1'b1, "R2 valid after sample", int'(out_valid), 1);
        chk(sl() == 1000, "R4 first left", sl(), 1000);
        chk(sr() == -500, "R4 first right", sr(), -500);
    endtask

    task automatic t_hold();
        int hl, hr;
        hl = sl(); hr = sr();
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R2 valid idle", int'(out_valid), 0);
        chk(sl() == hl, "R2 hold left", sl(), hl);
        chk(sr() == hr, "R2 hold right", sr(), hr);
    endtask

    task automatic t_patterns();
        do_clear();
        for (int i = 0; i < 300; i++) begin
            int sq, rp;
            sq = ((i / 16) % 2 == 0) ? 3000000 : -2000000;
            rp = (i * 37) - 5000 + 40000;
            push(sq, rp);
            cmp_model("R3 square/ramp");
        end
        for (int i = 0; i < 200; i++) begin
            push((i % 2 == 0) ? 1234567 : -1234567, 700000);
            cmp_model("R3 alternating/dc");
        end
    endtask

    task automatic t_decay();
        bit right_ok = 1'b1;
        int bad_r = 0;
        do_clear();
        for (int i = 0; i < 26000; i++) begin
            push(100000, 0);
            if (sr() != 0) begin right_ok = 1'b0; bad_r = sr(); end
            if (i % 1000 == 0) cmp_model("R3 decay track");
        end
        chk(sl() <= 1 && sl() >= -1, "R5 settled left", sl(), 0);
        chk(right_ok, "R9 right quiet", bad_r, 0);
    endtask

    task automatic t_sat();
        do_clear();
        push(SMIN, SMAX);
        chk(sl() == SMIN, "R4 min first", sl(), SMIN);
        push(SMAX, SMIN);
        chk(sl() == SMAX, "R6 positive clamp", sl(), SMAX);
        chk(sr() == SMIN, "R6 negative clamp", sr(), SMIN);
        cmp_model("R6 model");
    endtask

    task automatic t_bypass();
        do_clear();
        for (int i = 0; i < 40; i++) begin
            push(50000 + i * 100, -70000);
            cmp_model("R3 before bypass");
        end
        bypass = 1'b1;
        for (int i = 0; i < 20; i++) begin
            int xl;
            xl = 90000 - i * 333;
            push(xl, 12345);
            chk(sl() == xl, "R7 bypass left", sl(), xl);
            chk(sr() == 12345, "R7 bypass right", sr(), 12345);
        end
        bypass = 1'b0;
        for (int i = 0; i < 20; i++) begin
            push(20000, 20000);
            cmp_model("R7 after bypass");
        end
    endtask

    task automatic t_clear();
        push(400000, -400000);
        clear = 1'b1;
        in_valid = 1'b1;
        in_left = 24'd777;
        in_right = 24'd777;
        @(posedge clk);
        @(negedge clk);
        clear = 1'b0;
        in_valid = 1'b0;
        model_clear();
        chk(out_valid == 1'b0, "R8 valid dropped", int'(out_valid), 0);
        chk(sl() == 0, "R8 left zero", sl(), 0);
        chk(sr() == 0, "R8 right zero", sr(), 0);
        push(-3210, 6543);
        chk(sl() == -3210, "R8 fresh left", sl(), -3210);
        chk(sr() == 6543, "R8 fresh right", sr(), 6543);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first();
        t_hold();
        t_patterns();
        t_sat();
        t_bypass();
        t_clear();
        t_decay();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule